// File: doc/BRIEF.md
# FIFO status channel calendar generator

This block produces the 2-bit flow-control status stream that the receiving end of a packet link returns to its transmitting peer. A calendar RAM, written from a separate user clock, maps each slot position to a channel number. On every status clock the sequencer walks the calendar and sends the fill state of the channel named in the current slot. When the configured number of passes is complete, the block appends a 2-bit parity word and then a framing word. It then starts the next group at slot 0.

The fill state of each channel arrives on a flat vector, two bits per channel. Two conditions stop valid reporting. One is an out-of-frame flag from the local receiver. The other is a local almost-full flag whose effect depends on a mode input. Either the stream falls back to continuous framing, every slot reports "satisfied", or the flag is ignored. A test input corrupts one parity word so that error detection at the peer can be checked.

Top module: `fsc_cal_gen`

## Requirements
- R1: A calendar entry is written on a rising edge of `clk_user` only while `cal_wr_n` is 0; while `cal_wr_n` is 1 the address and data inputs leave the stored calendar unchanged.
- R2: In frame, slot words follow calendar order from slot 0. Each word is the 2-bit fill code of the channel stored in that slot, taken from `chan_fill[2*ch+1:2*ch]`. The codes are 00 starving, 01 hungry and 10 satisfied, and an input of 11 is reported as 10.
- R3: One group is `cal_len` slots repeated `cal_rep` times, then one parity word, then one framing word 11. A `cal_len` of 0 means the full calendar depth (512), and a `cal_rep` of 0 means 256 passes.
- R4: The parity word is the bitwise inverse of the XOR of every slot word sent since the last framing word.
- R5: A cycle with `force_par_err` high inverts both bits of the next parity word only. Later parity words are correct again.
- R6: While `rx_oof` is 1 the output is the framing word 11 continuously. After it falls, one framing word is sent and then slot 0 of pass 0.
- R7: With `af_flag` 1 and `af_mode` 00 the block behaves as in R6: continuous framing, then a restart at slot 0 once the flag clears.
- R8: With `af_flag` 1 and `af_mode` 01 every slot word is 10. The parity word is computed over those words.
- R9: With `af_mode` 10 or 11, `af_flag` has no effect on the stream.
- R10: During reset the output is 11. The first status clock after reset sends 11, and the next one sends slot 0 of pass 0.
- R11: The framing code 11 never appears in a calendar slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_user | input | 1 | Calendar load clock |
| cal_wr_n | input | 1 | Calendar write strobe, active low |
| cal_wr_addr | input | 9 | Slot index being written |
| cal_wr_chan | input | 8 | Channel number stored at that slot |
| clk_stat | input | 1 | Status stream clock |
| rst_n | input | 1 | Active-low reset of the status sequencer |
| cal_len | input | 9 | Slots per pass (0 = 512) |
| cal_rep | input | 8 | Passes per group (0 = 256) |
| chan_fill | input | 512 | Fill state per channel, 2 bits each |
| rx_oof | input | 1 | Local receiver out of frame |
| af_flag | input | 1 | Local FIFO almost full |
| af_mode | input | 2 | Almost-full response: 00 drop framing, 01 all satisfied, 1x ignore |
| force_par_err | input | 1 | Corrupt the next parity word |
| stat_out | output | 2 | Status word stream |

## Verification
The assertions check several properties on every cycle. The slot and pass counters must stay inside the configured length and repeat count. A parity word must always be followed by framing. No calendar slot may carry 11. A held out-of-frame or drop-framing condition must give a framing-only output, and the all-satisfied override must give code 10. Other behaviour depends on stored and accumulated content, so only the bench scenarios can show it. This covers the channel order taken from the calendar RAM, the parity value over a whole group, and the single-shot parity corruption. It also covers the boundary lengths and repeat counts, the exact restart sequence after framing loss, and the fact that a high write strobe leaves the calendar untouched.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

    typedef enum logic [1:0] {
        ST_FRAME  = 2'd0,
        ST_SLOT   = 2'd1,
        ST_PARITY = 2'd2
    } seq_state_e;

    localparam logic [1:0] CODE_STARVE = 2'b00;
    localparam logic [1:0] CODE_HUNGRY = 2'b01;
    localparam logic [1:0] CODE_SAT    = 2'b10;
    localparam logic [1:0] CODE_FRAME  = 2'b11;

    // A fill state of 11 cannot go on the wire inside a slot; report satisfied.
    function automatic logic [1:0] fill_to_code(input logic [1:0] fill);
        return (fill == CODE_FRAME) ? CODE_SAT : fill;
    endfunction

endpackage

// File: rtl/fsc_cal_ram.sv
module fsc_cal_ram #(
    parameter int DEPTH = 512,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk_wr,
    input  logic          wr_n,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk_wr) begin
        if (!wr_n) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/fsc_par_fold.sv
module fsc_par_fold (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       fold,
    input  logic [1:0] word,
    input  logic       inject,
    input  logic       emit,
    output logic [1:0] par_word
);

    typedef struct packed {
        logic [1:0] acc;
        logic       inj;
    } par_regs_t;

    par_regs_t par_d, par_q;

    always_comb begin
        par_d = par_q;
        if (clr) begin
            par_d.acc = 2'b00;
        end else if (fold) begin
            par_d.acc = par_q.acc ^ word;
        end
        par_d.inj = inject | (par_q.inj & ~emit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_q <= '0;
        end else begin
            par_q <= par_d;
        end
    end

    assign par_word = ~par_q.acc ^ {2{par_q.inj}};

    AST_INJECT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        inject |=> par_q.inj) else $error("pending parity corruption lost"); // R5

endmodule

// File: rtl/fsc_slot_seq.sv
module fsc_slot_seq
    import fsc_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int REP_W = 8,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] cal_len,
    input  logic [REP_W-1:0]  cal_rep,
    input  logic              hold,
    output seq_state_e        state,
    output logic [SLOT_W-1:0] slot
);

    typedef struct packed {
        seq_state_e        st;
        logic [SLOT_W-1:0] slot;
        logic [REP_W-1:0]  pass;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;

    logic [SLOT_W:0] len_eff;
    logic [REP_W:0]  rep_eff;
    logic            last_slot;
    logic            last_pass;

    always_comb begin
        len_eff   = (cal_len == '0) ? (SLOT_W+1)'(DEPTH) : {1'b0, cal_len};
        rep_eff   = (cal_rep == '0) ? {1'b1, {REP_W{1'b0}}} : {1'b0, cal_rep};
        last_slot = ({1'b0, seq_q.slot} == (len_eff - 1'b1));
        last_pass = ({1'b0, seq_q.pass} == (rep_eff - 1'b1));
    end

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_FRAME: begin
                seq_d.slot = '0;
                seq_d.pass = '0;
                if (!hold) begin
                    seq_d.st = ST_SLOT;
                end
            end
            ST_SLOT: begin
                if (hold) begin
                    seq_d.st   = ST_FRAME;
                    seq_d.slot = '0;
                    seq_d.pass = '0;
                end else if (last_slot) begin
                    seq_d.slot = '0;
                    if (last_pass) begin
                        seq_d.pass = '0;
                        seq_d.st   = ST_PARITY;
                    end else begin
                        seq_d.pass = seq_q.pass + 1'b1;
                    end
                end else begin
                    seq_d.slot = seq_q.slot + 1'b1;
                end
            end
            ST_PARITY: begin
                seq_d.st   = ST_FRAME;
                seq_d.slot = '0;
                seq_d.pass = '0;
            end
            default: begin
                seq_d = '{st: ST_FRAME, slot: '0, pass: '0};
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_FRAME, slot: '0, pass: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state = seq_q.st;
    assign slot  = seq_q.slot;

    AST_SLOT_IN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, seq_q.slot} < len_eff)) else $error("slot beyond length"); // R3
    AST_PASS_IN_REP: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, seq_q.pass} < rep_eff)) else $error("pass beyond repeat count"); // R3
    AST_PARITY_THEN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_PARITY) |=> (seq_q.st == ST_FRAME)) else $error("no framing after parity"); // R3
    AST_HOLD_FORCES_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (seq_q.st == ST_FRAME && seq_q.slot == '0)) else $error("hold did not drop to framing"); // R6

endmodule

// File: rtl/fsc_cal_gen.sv
module fsc_cal_gen
    import fsc_pkg::*;
#(
    parameter int CAL_DEPTH = 512,
    parameter int CHAN_W    = 8,
    parameter int REP_W     = 8,
    localparam int SLOT_W   = $clog2(CAL_DEPTH),
    localparam int NCHAN    = 1 << CHAN_W
) (
    input  logic              clk_user,
    input  logic              cal_wr_n,
    input  logic [SLOT_W-1:0] cal_wr_addr,
    input  logic [CHAN_W-1:0] cal_wr_chan,
    input  logic              clk_stat,
    input  logic              rst_n,
    input  logic [SLOT_W-1:0] cal_len,
    input  logic [REP_W-1:0]  cal_rep,
    input  logic [2*NCHAN-1:0] chan_fill,
    input  logic              rx_oof,
    input  logic              af_flag,
    input  logic [1:0]        af_mode,
    input  logic              force_par_err,
    output logic [1:0]        stat_out
);

    seq_state_e        seq_st;
    logic [SLOT_W-1:0] seq_slot;
    logic [CHAN_W-1:0] rd_chan;
    logic [CHAN_W:0]   fill_idx;
    logic [1:0]        slot_word;
    logic [1:0]        par_word;
    logic              hold;
    logic              sat_all;

    typedef struct packed {
        logic [1:0] stat;
    } out_regs_t;

    out_regs_t out_d, out_q;

    fsc_cal_ram #(
        .DEPTH (CAL_DEPTH),
        .DW    (CHAN_W)
    ) u_ram (
        .clk_wr  (clk_user),
        .wr_n    (cal_wr_n),
        .wr_addr (cal_wr_addr),
        .wr_data (cal_wr_chan),
        .rd_addr (seq_slot),
        .rd_data (rd_chan)
    );

    fsc_slot_seq #(
        .DEPTH (CAL_DEPTH),
        .REP_W (REP_W)
    ) u_seq (
        .clk     (clk_stat),
        .rst_n   (rst_n),
        .cal_len (cal_len),
        .cal_rep (cal_rep),
        .hold    (hold),
        .state   (seq_st),
        .slot    (seq_slot)
    );

    fsc_par_fold u_par (
        .clk      (clk_stat),
        .rst_n    (rst_n),
        .clr      (seq_st != ST_SLOT),
        .fold     (seq_st == ST_SLOT),
        .word     (slot_word),
        .inject   (force_par_err),
        .emit     (seq_st == ST_PARITY),
        .par_word (par_word)
    );

    always_comb begin
        hold      = rx_oof | (af_flag & (af_mode == 2'b00));
        sat_all   = af_flag & (af_mode == 2'b01);
        fill_idx  = {rd_chan, 1'b0};
        slot_word = sat_all ? CODE_SAT : fill_to_code(chan_fill[fill_idx +: 2]);
    end

    always_comb begin
        out_d = out_q;
        unique case (seq_st)
            ST_SLOT:   out_d.stat = slot_word;
            ST_PARITY: out_d.stat = par_word;
            default:   out_d.stat = CODE_FRAME;
        endcase
    end

    always_ff @(posedge clk_stat or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{stat: CODE_FRAME};
        end else begin
            out_q <= out_d;
        end
    end

    assign stat_out = out_q.stat;

    AST_NO_FRAME_IN_SLOT: assert property (@(posedge clk_stat) disable iff (!rst_n)
        (seq_st == ST_SLOT) |=> (stat_out != CODE_FRAME)) else $error("framing code in slot"); // R11
    AST_OOF_SENDS_FRAME: assert property (@(posedge clk_stat) disable iff (!rst_n)
        (rx_oof && $past(rx_oof)) |=> (stat_out == CODE_FRAME)) else $error("status sent while out of frame"); // R6
    AST_AF_DROPS_FRAME: assert property (@(posedge clk_stat) disable iff (!rst_n)
        (af_flag && af_mode == 2'b00 && $past(af_flag && af_mode == 2'b00))
        |=> (stat_out == CODE_FRAME)) else $error("status sent in drop-framing mode"); // R7
    AST_AF_ALL_SAT: assert property (@(posedge clk_stat) disable iff (!rst_n)
        (sat_all && seq_st == ST_SLOT) |=> (stat_out == CODE_SAT)) else $error("override not satisfied"); // R8

endmodule

// File: tb/fsc_cal_gen_tb.sv
`timescale 1ns/1ps
module fsc_cal_gen_tb;

    localparam int DEPTH = 512;
    localparam int NCH   = 256;

    logic         clk_stat = 1'b0;
    logic         clk_user = 1'b0;
    logic         rst_n = 1'b0;
    logic         cal_wr_n = 1'b1;
    logic [8:0]   cal_wr_addr = '0;
    logic [7:0]   cal_wr_chan = '0;
    logic [8:0]   cal_len = 9'd5;
    logic [7:0]   cal_rep = 8'd1;
    logic [2*NCH-1:0] chan_fill;
    logic         rx_oof = 1'b0;
    logic         af_flag = 1'b0;
    logic [1:0]   af_mode = 2'b10;
    logic         force_par_err = 1'b0;
    logic [1:0]   stat_out;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] model_cal [DEPTH];

    always #4 clk_stat = ~clk_stat;
    always #5 clk_user = ~clk_user;

    fsc_cal_gen u_dut (
        .clk_user      (clk_user),
        .cal_wr_n      (cal_wr_n),
        .cal_wr_addr   (cal_wr_addr),
        .cal_wr_chan   (cal_wr_chan),
        .clk_stat      (clk_stat),
        .rst_n         (rst_n),
        .cal_len       (cal_len),
        .cal_rep       (cal_rep),
        .chan_fill     (chan_fill),
        .rx_oof        (rx_oof),
        .af_flag       (af_flag),
        .af_mode       (af_mode),
        .force_par_err (force_par_err),
        .stat_out      (stat_out)
    );

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: stat_out=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] code_of(input int ch);
        logic [1:0] f;
        f = chan_fill[2*ch +: 2];
        return (f == 2'b11) ? 2'b10 : f;
    endfunction

    task automatic write_cal(input int addr, input logic [7:0] ch, input logic strobe_n);
        @(negedge clk_user);
        cal_wr_n    = strobe_n;
        cal_wr_addr = 9'(addr);
        cal_wr_chan = ch;
        @(negedge clk_user);
        cal_wr_n = 1'b1;
        if (!strobe_n) model_cal[addr] = ch;
    endtask

    task automatic load_cal();
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk_user);
            cal_wr_n    = 1'b0;
            cal_wr_addr = 9'(i);
            cal_wr_chan = 8'((i * 37 + 5) % 256);
            model_cal[i] = 8'((i * 37 + 5) % 256);
        end
        @(negedge clk_user);
        cal_wr_n = 1'b1;
    endtask

    task automatic restart(input logic [8:0] len, input logic [7:0] rep);
        @(negedge clk_stat);
        rst_n   = 1'b0;
        cal_len = len;
        cal_rep = rep;
        repeat (2) @(negedge clk_stat);
        rst_n = 1'b1;
    endtask

    // Checks nfr complete groups; starts at the current sample, skipping framing.
    task automatic run_frames(input int nfr, input bit sat, input bit inj, input string req);
        int le, re, w;
        logic [1:0] acc, exp;
        le = (cal_len == 0) ? DEPTH : int'(cal_len);
        re = (cal_rep == 0) ? 256 : int'(cal_rep);
        w = 0;
        while (stat_out == 2'b11 && w < 50) begin
            @(negedge clk_stat);
            w++;
        end
        if (w >= 50) begin
            n_chk++;
            n_fail++;
            $display("FAIL %s: never left framing, stat_out=%b expected slot word", req, stat_out);
            return;
        end
        for (int fr = 0; fr < nfr; fr++) begin
            acc = 2'b00;
            for (int p = 0; p < re; p++) begin
                for (int s = 0; s < le; s++) begin
                    exp = sat ? 2'b10 : code_of(int'(model_cal[s]));
                    chk({req, " slot (R2 R11)"}, stat_out, exp);
                    acc ^= exp;
                    if (inj && fr == 0 && p == 0 && s == 0) force_par_err = 1'b1;
                    @(negedge clk_stat);
                    force_par_err = 1'b0;
                end
            end
            exp = ~acc;
            if (inj && fr == 0) exp = ~exp;
            chk(inj ? "R5 parity" : "R4 parity", stat_out, exp);
            @(negedge clk_stat);
            chk("R3 framing", stat_out, 2'b11);
            @(negedge clk_stat);
        end
    endtask

    task automatic t_reset();
        @(negedge clk_stat);
        rst_n = 1'b0;
        cal_len = 9'd3;
        cal_rep = 8'd1;
        repeat (2) @(negedge clk_stat);
        chk("R10 in reset", stat_out, 2'b11);
        rst_n = 1'b1;
        @(negedge clk_stat);
        chk("R10 first word", stat_out, 2'b11);
        @(negedge clk_stat);
        chk("R10 slot 0", stat_out, code_of(int'(model_cal[0])));
    endtask

    task automatic t_basic();
        restart(9'd5, 8'd3);
        run_frames(2, 1'b0, 1'b0, "R3 len5 rep3");
        restart(9'd1, 8'd1);
        run_frames(3, 1'b0, 1'b0, "R3 len1 rep1");
        restart(9'd0, 8'd1);
        run_frames(1, 1'b0, 1'b0, "R3 len0 full depth");
        restart(9'd2, 8'd0);
        run_frames(1, 1'b0, 1'b0, "R3 rep0 256 passes");
    endtask

    task automatic t_inject();
        restart(9'd4, 8'd2);
        run_frames(2, 1'b0, 1'b1, "R5 inject");
    endtask

    task automatic t_hold(input bit use_af, input string req);
        restart(9'd5, 8'd2);
        run_frames(1, 1'b0, 1'b0, req);
        if (use_af) begin
            af_mode = 2'b00;
            af_flag = 1'b1;
        end else begin
            rx_oof = 1'b1;
        end
        repeat (2) @(negedge clk_stat);
        for (int i = 0; i < 20; i++) begin
            chk({req, " held framing"}, stat_out, 2'b11);
            @(negedge clk_stat);
        end
        af_flag = 1'b0;
        rx_oof  = 1'b0;
        @(negedge clk_stat);
        chk({req, " one framing word"}, stat_out, 2'b11);
        @(negedge clk_stat);
        chk({req, " restart slot 0"}, stat_out, code_of(int'(model_cal[0])));
        run_frames(1, 1'b0, 1'b0, req);
        af_mode = 2'b10;
    endtask

    task automatic t_af_modes();
        af_mode = 2'b01;
        af_flag = 1'b1;
        restart(9'd6, 8'd2);
        run_frames(2, 1'b1, 1'b0, "R8 all satisfied");
        af_mode = 2'b10;
        restart(9'd6, 8'd2);
        run_frames(1, 1'b0, 1'b0, "R9 mode 10");
        af_mode = 2'b11;
        restart(9'd7, 8'd1);
        run_frames(1, 1'b0, 1'b0, "R9 mode 11");
        af_flag = 1'b0;
        af_mode = 2'b10;
    endtask

    task automatic t_write_strobe();
        int c;
        c = 0;
        while (code_of(c) == code_of(int'(model_cal[0]))) c++;
        @(negedge clk_stat);
        rst_n = 1'b0;
        write_cal(0, 8'(c), 1'b1);      // R1: strobe high, must not store
        restart(9'd3, 8'd1);
        run_frames(1, 1'b0, 1'b0, "R1 strobe high ignored");
        @(negedge clk_stat);
        rst_n = 1'b0;
        write_cal(0, 8'(c), 1'b0);      // R1: strobe low stores
        restart(9'd3, 8'd1);
        run_frames(1, 1'b0, 1'b0, "R1 strobe low writes");
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) chan_fill[2*i +: 2] = 2'((i * 3 + i / 5) % 4);
        load_cal();
        t_reset();
        t_basic();
        t_inject();
        t_hold(1'b0, "R6 rx_oof");
        t_hold(1'b1, "R7 af drop");
        t_af_modes();
        t_write_strobe();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run hung, stat_out=%b expected completion", stat_out);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule